// File: doc/BRIEF.md
# Addressable Asynchronous Serial Port

A full-duplex asynchronous serial port run by one 8-bit control register and one data register on a small register bus. It sends and receives frames either with eight data bits or with nine, where the extra bit comes from a control bit on transmit and lands in a control bit on receive. The bit rate comes from an external tick that pulses sixteen times per bit period (parameter `OSR`). No baud generator or FIFO is included.

Each bit on the line takes `OSR` ticks. The receiver finds the start bit on a falling line level and votes three samples taken around the middle of each bit. A single filter enable serves two purposes. In nine-bit frames it makes the port ignore every frame whose ninth bit is 0, so a receiver can wait for an address frame. In eight-bit frames it makes the port drop frames with a broken stop bit. Two sticky flags, transmit-done and receive-done, drive one interrupt line.

Top module: `addr_serial_port`

## Requirements
- R1: After reset the control register reads 0x40, `txd` is 1 and `irq` is 0.
- R2: Control bit 6 always reads as 1, and writes to it have no effect. The control bits are: bit 7 frame length (0 = eight data bits, 1 = nine), bit 5 filter enable, bit 4 receive enable, bit 3 ninth transmit bit, bit 2 ninth receive bit, bit 1 transmit flag, bit 0 receive flag. `bus_sel` = 0 selects control and `bus_sel` = 1 selects data.
- R3: A write to the data register while the transmitter is idle sends a frame. The frame is a 0 start bit, then the eight data bits least significant first, then (in nine-bit mode only) control bit 3, then a 1 stop bit. Each bit lasts `OSR` ticks.
- R4: The transmit flag is set when the stop bit begins. In eight-bit mode this is right after the eighth data bit, and in nine-bit mode right after the ninth bit.
- R5: When a frame is accepted, its eight data bits become readable at the data register, the receive flag is set when the stop bit is sampled, and control bit 2 takes the stop bit value (eight-bit mode) or the ninth data bit (nine-bit mode).
- R6: In nine-bit mode with the filter enabled, a frame whose ninth bit is 0 sets no flag and leaves the data register unchanged. A frame whose ninth bit is 1 is accepted. With the filter off, the ninth bit does not matter.
- R7: In eight-bit mode with the filter enabled, a frame whose stop bit samples 0 is dropped and the data register is unchanged. With the filter off, such a frame is accepted and control bit 2 reads 0.
- R8: While receive enable is 0, no frame sets the receive flag or changes the data register.
- R9: Both flags stay at 1 until software writes 0 to them. Hardware never clears them.
- R10: `irq` is 1 exactly when `irq_en` is 1 and at least one flag is set.
- R11: A low pulse on `rxd` that is back high before the middle of the start bit is ignored, and the receiver then accepts the next real frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_x16 | input | 1 | One-cycle pulse, `OSR` pulses per bit |
| bus_sel | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Interrupt request |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The bench aims at the places where the shared filter bit changes meaning with the frame length. A design that checked the wrong bit would accept an address-mismatch frame, or drop a valid eight-bit frame with a bad stop bit even though filtering is off. It also checks that a rejected frame leaves the data register unchanged, and that a short glitch neither produces a 0xFF byte nor stops the next real frame from being received. Transmit-flag timing is checked in a window that separates the start of the stop bit from the last data bit, in both frame lengths. This catches a flag that is raised one bit early or one bit late.

// File: rtl/addr_serial_port.sv
module addr_serial_port #(
  parameter int OSR = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_x16,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       irq_en,
  output logic       irq,
  input  logic       rxd,
  output logic       txd
);
  localparam int CW  = $clog2(OSR);
  localparam int MID = OSR / 2;

  logic       mode_q, mce_q, ren_q, tb8_q, rb8_q, ti_q, ri_q;
  logic [7:0] rbuf_q;
  logic       ctrl_wr, data_wr;

  assign ctrl_wr   = bus_wr & ~bus_sel;
  assign data_wr   = bus_wr & bus_sel;
  assign bus_rdata = bus_sel ? rbuf_q : {mode_q, 1'b1, mce_q, ren_q, tb8_q, rb8_q, ti_q, ri_q};
  assign irq       = irq_en & (ri_q | ti_q);

  // transmitter
  logic          tx_busy, txd_q;
  logic [CW-1:0] tx_cnt;
  logic [3:0]    tx_left;
  logic [9:0]    tx_sh;
  logic          tx_edge, ti_set;

  assign tx_edge = tx_busy && baud_x16 && tx_cnt == CW'(OSR - 1);
  assign ti_set  = tx_edge && tx_left == 4'd1;
  assign txd     = txd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      txd_q   <= 1'b1;
      tx_cnt  <= '0;
      tx_left <= '0;
      tx_sh   <= '1;
    end else if (!tx_busy) begin
      if (data_wr) begin
        tx_busy <= 1'b1;
        tx_cnt  <= '0;
        txd_q   <= 1'b0;
        tx_sh   <= {1'b1, mode_q ? tb8_q : 1'b1, bus_wdata};
        tx_left <= mode_q ? 4'd10 : 4'd9;
      end
    end else if (baud_x16) begin
      tx_cnt <= (tx_cnt == CW'(OSR - 1)) ? '0 : tx_cnt + 1'b1;
      if (tx_edge) begin
        if (tx_left == 4'd0) tx_busy <= 1'b0;
        else begin
          txd_q   <= tx_sh[0];
          tx_sh   <= {1'b1, tx_sh[9:1]};
          tx_left <= tx_left - 4'd1;
        end
      end
    end
  end

  // receiver
  logic          rx_s1, rx_s2, rx_prev, rx_busy, rx_b9, smp_a, smp_b;
  logic [CW-1:0] rx_cnt;
  logic [3:0]    rx_idx;
  logic [7:0]    rx_sh;
  logic          vote, rx_dec, rx_done, ninth, ri_set;

  assign vote    = (smp_a & smp_b) | (smp_a & rx_s2) | (smp_b & rx_s2);
  assign rx_dec  = rx_busy && baud_x16 && rx_cnt == CW'(MID + 1);
  assign rx_done = rx_dec && rx_idx == (mode_q ? 4'd10 : 4'd9);
  assign ninth   = mode_q ? rx_b9 : vote;
  assign ri_set  = rx_done && ren_q && (!mce_q || ninth);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_s1   <= 1'b1;
      rx_s2   <= 1'b1;
      rx_prev <= 1'b1;
      rx_busy <= 1'b0;
      rx_cnt  <= '0;
      rx_idx  <= '0;
      rx_sh   <= '0;
      rx_b9   <= 1'b0;
      smp_a   <= 1'b1;
      smp_b   <= 1'b1;
    end else begin
      rx_s1 <= rxd;
      rx_s2 <= rx_s1;
      if (baud_x16) rx_prev <= rx_s2;
      if (!ren_q) rx_busy <= 1'b0;
      else if (!rx_busy) begin
        if (baud_x16 && rx_prev && !rx_s2) begin
          rx_busy <= 1'b1;
          rx_cnt  <= '0;
          rx_idx  <= '0;
        end
      end else if (baud_x16) begin
        rx_cnt <= (rx_cnt == CW'(OSR - 1)) ? '0 : rx_cnt + 1'b1;
        if (rx_cnt == CW'(OSR - 1)) rx_idx <= rx_idx + 4'd1;
        if (rx_cnt == CW'(MID - 1)) smp_a <= rx_s2;
        if (rx_cnt == CW'(MID))     smp_b <= rx_s2;
        if (rx_dec) begin
          if (rx_idx == 4'd0 && vote) rx_busy <= 1'b0;
          else if (rx_idx >= 4'd1 && rx_idx <= 4'd8) rx_sh <= {vote, rx_sh[7:1]};
          else if (rx_idx == 4'd9 && mode_q) rx_b9 <= vote;
          if (rx_done) rx_busy <= 1'b0;
        end
      end
    end
  end

  // control and data registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {mode_q, mce_q, ren_q, tb8_q, rb8_q, ti_q, ri_q} <= '0;
      rbuf_q <= '0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= bus_wdata[7];
        mce_q  <= bus_wdata[5];
        ren_q  <= bus_wdata[4];
        tb8_q  <= bus_wdata[3];
        rb8_q  <= bus_wdata[2];
        ti_q   <= bus_wdata[1];
        ri_q   <= bus_wdata[0];
      end
      if (ri_set) begin
        ri_q   <= 1'b1;
        rbuf_q <= rx_sh;
        rb8_q  <= ninth;
      end
      if (ti_set) ti_q <= 1'b1;
    end
  end

  assert_ri_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ri_q && !ctrl_wr |=> ri_q);
  assert_ti_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ti_q && !ctrl_wr |=> ti_q);
  assert_ti_at_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ti_q) && !$past(ctrl_wr) |-> txd);
  assert_addr_filter_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri_q) && !$past(ctrl_wr) && mode_q && mce_q |-> rb8_q);
  assert_stop_filter_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri_q) && !$past(ctrl_wr) && !mode_q && mce_q |-> rb8_q);
  assert_rx_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ren_q && !ctrl_wr |=> !$rose(ri_q));
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en && (ri_q || ti_q));
endmodule

// File: tb/addr_serial_port_test.sv
module addr_serial_port_test;
  localparam int BIT = 32;

  logic       clk = 1'b0, rst_n = 1'b0, baud_x16 = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0, irq_en = 1'b0, rxd = 1'b1;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, txd;

  int n_chk = 0, n_bad = 0;
  logic [9:0] exp_q[$];

  addr_serial_port #(.OSR(16)) uut (
    .clk(clk), .rst_n(rst_n), .baud_x16(baud_x16), .bus_sel(bus_sel),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_en(irq_en), .irq(irq), .rxd(rxd), .txd(txd));

  always #10 clk = ~clk;

  initial forever begin
    @(negedge clk);
    baud_x16 = ~baud_x16;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic s, output logic [7:0] v);
    @(negedge clk);
    bus_sel = s;
    #1 v = bus_rdata;
  endtask

  task automatic send_rx(input logic [7:0] d, input logic nine_en, input logic nine, input logic stop);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (nine_en) begin
      rxd = nine;
      repeat (BIT) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic tx_frame(input logic mode, input logic nine, input logic [7:0] d);
    exp_q.push_back({mode, nine, d});
    wr(1'b1, d);
  endtask

  // monitor: decodes txd and compares against the scoreboard queue
  initial begin
    @(posedge rst_n);
    forever begin
      logic [9:0] e;
      logic [7:0] got;
      logic       b9, st, sb;
      @(negedge txd);
      repeat (BIT / 2) @(negedge clk);
      sb = txd;
      for (int i = 0; i < 8; i++) begin
        repeat (BIT) @(negedge clk);
        got[i] = txd;
      end
      if (exp_q.size() == 0) begin
        check("R3 unexpected frame", 1, 0);
        continue;
      end
      e = exp_q.pop_front();
      b9 = 1'b1;
      if (e[9]) begin
        repeat (BIT) @(negedge clk);
        b9 = txd;
        check("R3 ninth bit", b9, e[8]);
      end
      repeat (BIT) @(negedge clk);
      st = txd;
      check("R3 start bit", sb, 0);
      check("R3 data", got, e[7:0]);
      check("R3 stop bit", st, 1);
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b0, v); check("R1 ctrl reset", v, 8'h40);
    check("R1 txd idle", txd, 1);
    check("R1 irq", irq, 0);

    wr(1'b0, 8'h00); rd(1'b0, v); check("R2 bit6 stays 1", v, 8'h40);
    wr(1'b0, 8'h3C); rd(1'b0, v); check("R2 readback", v, 8'h7C);

    wr(1'b0, 8'h13); #1 check("R10 irq gated off", irq, 0);
    irq_en = 1'b1; #1 check("R10 irq on", irq, 1);
    wr(1'b0, 8'h10); #1 check("R10 irq after clear", irq, 0);

    // eight-bit, filter off
    send_rx(8'hA5, 1'b0, 1'b0, 1'b1);
    rd(1'b0, v); check("R5 ri/rb8 8-bit", v & 8'h05, 8'h05);
    check("R10 irq from ri", irq, 1);
    rd(1'b1, v); check("R5 data 8-bit", v, 8'hA5);
    repeat (100) @(negedge clk);
    rd(1'b0, v); check("R9 ri held", v & 8'h01, 8'h01);
    wr(1'b0, 8'h10); rd(1'b0, v); check("R9 ri cleared by sw", v & 8'h01, 0);

    send_rx(8'h3C, 1'b0, 1'b0, 1'b0);
    rd(1'b0, v); check("R7 bad stop accepted, filter off", v & 8'h05, 8'h01);
    rd(1'b1, v); check("R7 data filter off", v, 8'h3C);

    // eight-bit, stop check on
    wr(1'b0, 8'h30);
    send_rx(8'h5A, 1'b0, 1'b0, 1'b0);
    rd(1'b0, v); check("R7 bad stop dropped", v & 8'h01, 0);
    rd(1'b1, v); check("R7 data kept", v, 8'h3C);
    send_rx(8'h5A, 1'b0, 1'b0, 1'b1);
    rd(1'b0, v); check("R7 good stop accepted", v & 8'h05, 8'h05);
    rd(1'b1, v); check("R7 data good stop", v, 8'h5A);

    // nine-bit, address filter on
    wr(1'b0, 8'hB0);
    send_rx(8'h11, 1'b1, 1'b0, 1'b1);
    rd(1'b0, v); check("R6 ninth 0 filtered", v & 8'h01, 0);
    rd(1'b1, v); check("R6 data kept", v, 8'h5A);
    send_rx(8'h22, 1'b1, 1'b1, 1'b1);
    rd(1'b0, v); check("R6 ninth 1 accepted", v & 8'h05, 8'h05);
    rd(1'b1, v); check("R6 data", v, 8'h22);

    // nine-bit, filter off
    wr(1'b0, 8'h90);
    send_rx(8'h33, 1'b1, 1'b0, 1'b1);
    rd(1'b0, v); check("R5 ri/rb8 9-bit", v & 8'h05, 8'h01);
    rd(1'b1, v); check("R5 data 9-bit", v, 8'h33);

    // receive disabled
    wr(1'b0, 8'h80);
    send_rx(8'h44, 1'b1, 1'b1, 1'b1);
    rd(1'b0, v); check("R8 no ri when disabled", v & 8'h01, 0);
    rd(1'b1, v); check("R8 data kept", v, 8'h33);

    // glitch rejection
    wr(1'b0, 8'h10);
    @(negedge clk); rxd = 1'b0;
    repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (12 * BIT) @(negedge clk);
    rd(1'b0, v); check("R11 glitch no ri", v & 8'h01, 0);
    rd(1'b1, v); check("R11 glitch data kept", v, 8'h33);
    send_rx(8'h66, 1'b0, 1'b0, 1'b1);
    rd(1'b0, v); check("R11 frame after glitch", v & 8'h01, 8'h01);
    rd(1'b1, v); check("R11 data after glitch", v, 8'h66);

    // transmit, eight-bit
    wr(1'b0, 8'h08);
    tx_frame(1'b0, 1'b1, 8'hC3);
    repeat (272) @(negedge clk);
    rd(1'b0, v); check("R4 ti not before stop 8-bit", v & 8'h02, 0);
    repeat (32) @(negedge clk);
    rd(1'b0, v); check("R4 ti at stop 8-bit", v & 8'h02, 8'h02);
    repeat (100) @(negedge clk);
    rd(1'b0, v); check("R9 ti held", v & 8'h02, 8'h02);

    // transmit, nine-bit
    wr(1'b0, 8'h88);
    tx_frame(1'b1, 1'b1, 8'h0F);
    repeat (304) @(negedge clk);
    rd(1'b0, v); check("R4 ti not before stop 9-bit", v & 8'h02, 0);
    repeat (32) @(negedge clk);
    rd(1'b0, v); check("R4 ti at stop 9-bit", v & 8'h02, 8'h02);
    repeat (100) @(negedge clk);
    wr(1'b0, 8'h80);
    tx_frame(1'b1, 1'b0, 8'hF0);
    repeat (450) @(negedge clk);
    check("R3 all frames seen", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule